// File: doc/BRIEF.md
# Spread-Spectrum Oscillator Trim Modulator

This block drives the trim code of an on-chip oscillator whose period is set by a 7-bit code. A larger code gives a longer period, so a code of zero is the fastest setting and the all-ones code is the slowest. With modulation turned off, the block passes the stored calibration code straight through. With modulation turned on, it adds a stepped triangular offset to the calibration code. The oscillator then sweeps its frequency evenly above and below the calibrated center, which spreads the energy of its emissions over a band.

The block runs in the oscillator's own clock domain. The offset is an index from -3 to +3. The index takes one step per interval of 32 clocks and traces a triangle with 12 intervals, so one sweep lasts 384 clocks. Each index unit is worth a programmable number of trim LSBs. The index times that weight is added to the calibration code, and the sum is clamped to the legal code range. The calibration code and the step weight are taken in only at interval boundaries. A change made in the middle of an interval therefore never moves the code part way through an interval.

Top module: `ssc_trim_mod`

## Requirements
- R1: While `mod_en` is 0, `trim_code` equals `cal_code` in the same cycle, combinationally, and this also holds while reset is active.
- R2: While `mod_en` is 1, the step index and the captured calibration code change only on every 32nd rising edge counted since modulation was enabled.
- R3: The step index runs through 0, +1, +2, +3, +2, +1, 0, -1, -2, -3, -2, -1 and then repeats. It holds each value for 32 clocks, so one sweep is 384 clocks.
- R4: The offset added to the calibration code is the step index multiplied by `step_lsb`, a 3-bit unsigned weight in trim LSBs. A weight of 0 leaves the code unmodulated.
- R5: A positive offset raises the code, which gives a slower oscillator. A sum above 127 is clamped to 127 and never wraps.
- R6: A negative offset lowers the code. A sum below 0 is clamped to 0 and never wraps.
- R7: Clearing `mod_en` resets the interval counter and the step index to zero. Enabling again restarts the sweep at index 0 with a full 32-clock interval.
- R8: While modulation is enabled, new values of `cal_code` and `step_lsb` take effect only at the next interval boundary. While it is disabled, they are captured on every clock.
- R9: `rst_n` is active low. It resets the block asynchronously and is released through a two-stage synchronizer. After release, the counter and the index start from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Spread-spectrum enable |
| cal_code | input | 7 | Calibration trim code (center frequency) |
| step_lsb | input | 3 | Trim LSBs applied per step index unit |
| trim_code | output | 7 | Modulated trim code to the oscillator |

## Verification
A behavioural model tracks the number of enabled clocks and predicts the code on every cycle. It is run first with a mid-range code and unit weight, which checks the order of the triangle and the 32-clock dwell. It is then run with a weight of 3, which tells scaling apart from plain index addition. Codes near 127 and near 0, with large weights, force the two clamps, which a wrapping adder would fail. Finally, calibration and weight are changed mid-interval, modulation is toggled mid-sweep, and reset is asserted while enabled. These cases separate boundary-only capture and a clean restart from designs that update immediately or resume where they left off.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Signed step index of a triangle with peak `half`, for phase p in 0..4*half-1
  function automatic int tri_index(input int p, input int half);
    if (p <= half)          return p;
    else if (p <= 3 * half) return 2 * half - p;
    else                    return p - 4 * half;
  endfunction
endpackage

// File: rtl/ssc_interval_timer.sv
module ssc_interval_timer #(
  parameter int INTERVAL = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(INTERVAL);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a disabled cycle leaves the counter at zero
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
  // R2: counting advances by one inside an interval
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/ssc_tri_seq.sv
module ssc_tri_seq #(
  parameter int HALF  = 3,
  parameter int OFF_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    tick,
  output logic [$clog2(4*HALF)-1:0] phase,
  output logic signed [OFF_W-1:0] offset
);
  import ssc_pkg::*;
  localparam int PHASES = 4 * HALF;
  localparam int PH_W   = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run)      ph_d = '0;
    else if (tick) ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase  = ph_q;
  assign offset = OFF_W'(tri_index(int'(ph_q), HALF));

  // R3: the sweep wraps from its last phase back to the start
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && ph_q == PH_LAST) |=> ph_q == '0);
  // R2: the phase holds between interval boundaries
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(ph_q));
  // R3: the index never leaves the symmetric limit
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (offset <= OFF_W'(HALF)) && (offset >= -OFF_W'(HALF)));
endmodule

// File: rtl/ssc_trim_sum.sv
module ssc_trim_sum #(
  parameter int TRIM_W = 7,
  parameter int STEP_W = 3,
  parameter int OFF_W  = 3
) (
  input  logic [TRIM_W-1:0]       cal,
  input  logic [STEP_W-1:0]       step,
  input  logic signed [OFF_W-1:0] offset,
  output logic [TRIM_W-1:0]       code
);
  localparam int SUM_W = TRIM_W + STEP_W + OFF_W + 1;
  localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((2 ** TRIM_W) - 1);

  logic signed [SUM_W-1:0] cal_x, step_x, off_x, sum;

  always_comb begin
    cal_x  = SUM_W'({1'b0, cal});
    step_x = SUM_W'({1'b0, step});
    off_x  = SUM_W'(offset);
    sum    = cal_x + off_x * step_x;
    if (sum < 0)             code = '0;
    else if (sum > CODE_MAX) code = '1;
    else                     code = sum[TRIM_W-1:0];
  end
endmodule

// File: rtl/ssc_trim_mod.sv
module ssc_trim_mod #(
  parameter int TRIM_W   = 7,
  parameter int STEP_W   = 3,
  parameter int INTERVAL = 32,
  parameter int HALF     = 3
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [TRIM_W-1:0] cal_code,
  input  logic [STEP_W-1:0] step_lsb,
  output logic [TRIM_W-1:0] trim_code
);
  localparam int OFF_W = $clog2(HALF + 1) + 1;
  localparam int PH_W  = $clog2(4 * HALF);
  localparam logic [STEP_W-1:0] STEP_RST = STEP_W'(1);

  // reset: asynchronous assert, synchronous release (R9)
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                    tick;
  logic [PH_W-1:0]         phase;
  logic signed [OFF_W-1:0] offset;
  logic [TRIM_W-1:0]       cal_q, cal_d, mod_code;
  logic [STEP_W-1:0]       step_q, step_d;
  logic                    capture;

  ssc_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk_osc), .rst_n(rst_int_n), .run(mod_en), .tick(tick));

  ssc_tri_seq #(.HALF(HALF), .OFF_W(OFF_W)) u_seq (
    .clk(clk_osc), .rst_n(rst_int_n), .run(mod_en), .tick(tick),
    .phase(phase), .offset(offset));

  // capture calibration and weight while idle or at an interval boundary (R8)
  assign capture = !mod_en || tick;

  always_comb begin
    cal_d  = cal_q;
    step_d = step_q;
    if (capture) begin
      cal_d  = cal_code;
      step_d = step_lsb;
    end
  end

  always_ff @(posedge clk_osc or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cal_q  <= '0;
      step_q <= STEP_RST;
    end else begin
      cal_q  <= cal_d;
      step_q <= step_d;
    end
  end

  ssc_trim_sum #(.TRIM_W(TRIM_W), .STEP_W(STEP_W), .OFF_W(OFF_W)) u_sum (
    .cal(cal_q), .step(step_q), .offset(offset), .code(mod_code));

  assign trim_code = mod_en ? mod_code : cal_code;

  // R1: disabled output follows the calibration input
  p_bypass_r1: assert property (@(posedge clk_osc)
    !mod_en |-> trim_code == cal_code);
  // R8: captured calibration holds inside an interval
  p_cal_hold_r8: assert property (@(posedge clk_osc) disable iff (!rst_int_n)
    (mod_en && !tick) |=> ($stable(cal_q) && $stable(step_q)));
  // R5: a non-negative offset never lowers the code
  p_up_r5: assert property (@(posedge clk_osc) disable iff (!rst_int_n)
    (mod_en && offset >= 0) |-> trim_code >= cal_q);
  // R6: a non-positive offset never raises the code
  p_down_r6: assert property (@(posedge clk_osc) disable iff (!rst_int_n)
    (mod_en && offset <= 0) |-> trim_code <= cal_q);
  // R7: re-enable starts at phase zero
  p_restart_r7: assert property (@(posedge clk_osc) disable iff (!rst_int_n)
    !mod_en |=> phase == '0);
  // R9: while in internal reset the sweep sits at its start
  p_reset_r9: assert property (@(posedge clk_osc)
    !rst_int_n |-> phase == '0);
endmodule

// File: tb/test_ssc_trim_mod.sv
module test_ssc_trim_mod;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mod_en;
  logic [6:0] cal_code;
  logic [2:0] step_lsb;
  logic [6:0] trim_code;

  ssc_trim_mod i_ssc_trim_mod (
    .clk_osc(clk), .rst_n(rst_n), .mod_en(mod_en),
    .cal_code(cal_code), .step_lsb(step_lsb), .trim_code(trim_code));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  string tag = "R9";
  bit finished = 1'b0;

  // behavioural reference: count enabled edges, look up the sweep
  int tri_tbl [12] = '{0, 1, 2, 3, 2, 1, 0, -1, -2, -3, -2, -1};
  int m_k = 0;
  int m_cal = 0;
  int m_step = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_k = 0; m_cal = 0; m_step = 1;
    end else if (!mod_en) begin
      m_k = 0; m_cal = int'(cal_code); m_step = int'(step_lsb);
    end else begin
      m_k = m_k + 1;
      if (m_k % 32 == 0) begin
        m_cal = int'(cal_code); m_step = int'(step_lsb);
      end
    end
  end

  function automatic int expected();
    int v;
    if (!mod_en) return int'(cal_code);
    v = m_cal + tri_tbl[(m_k / 32) % 12] * m_step;
    if (v < 0) v = 0;
    if (v > 127) v = 127;
    return v;
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (int'(trim_code) !== expected()) begin
        errors++;
        $display("FAIL %s: trim_code=%0d expected=%0d (enabled clocks=%0d)",
                 tag, trim_code, expected(), m_k);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; mod_en = 1'b0; cal_code = 7'd45; step_lsb = 3'd1;
    tag = "R9 reset with R1 bypass";
    run(5);
    @(negedge clk); rst_n = 1'b1;
    run(4);

    tag = "R1 bypass while disabled";
    for (int i = 0; i < 20; i++) begin
      cal_code = 7'(i * 13 + 3);
      step_lsb = 3'(i);
      run(1);
    end

    tag = "R2 R3 unit sweep";
    cal_code = 7'd64; step_lsb = 3'd1; run(2);
    mod_en = 1'b1; run(400);

    tag = "R7 disable clears sweep";
    mod_en = 1'b0; run(3);
    tag = "R4 weight of three";
    step_lsb = 3'd3; run(2);
    mod_en = 1'b1; run(400);

    tag = "R4 zero weight";
    mod_en = 1'b0; step_lsb = 3'd0; run(2);
    mod_en = 1'b1; run(130);

    tag = "R5 clamp at top";
    mod_en = 1'b0; cal_code = 7'd126; step_lsb = 3'd2; run(2);
    mod_en = 1'b1; run(400);

    tag = "R6 clamp at bottom";
    mod_en = 1'b0; cal_code = 7'd1; step_lsb = 3'd3; run(2);
    mod_en = 1'b1; run(400);

    tag = "R8 boundary capture";
    mod_en = 1'b0; cal_code = 7'd64; step_lsb = 3'd1; run(2);
    mod_en = 1'b1; run(45);
    cal_code = 7'd80; step_lsb = 3'd4; run(40);
    cal_code = 7'd20; run(70);

    tag = "R7 restart mid sweep";
    mod_en = 1'b0; run(1);
    mod_en = 1'b1; run(100);
    mod_en = 1'b0; run(1);
    mod_en = 1'b1; run(60);

    tag = "R9 reset while enabled";
    rst_n = 1'b0; run(3);
    mod_en = 1'b0; run(1);
    rst_n = 1'b1; run(4);
    mod_en = 1'b1; run(100);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule